// File: doc/BRIEF.md
# Shared EEPROM and PHY Word Access Sequencer

This block gives a host one small register window for single-word transfers to two targets: a configuration EEPROM and the management register space of an on-chip PHY. The host loads a target address and, for writes, a 16-bit data word. It then writes a command byte that picks the direction and the target. The block raises a busy flag, runs one request/acknowledge handshake on the chosen target port and drops busy once the target acknowledges. The host polls busy, collects the read word from the data bytes, and writes zero to the command register to return to idle.

Each target port is a plain word interface: a request held high, a write flag, a word offset, write data, read data and a one-cycle acknowledge. EEPROM writes are guarded by a separate enable bit in the command byte. An unenabled write finishes without touching the target.

The host window has four byte locations: command at 0, address at 1, data low byte at 2 and data high byte at 3. The host reads them through a combinational read mux.

Top module: `shared_cfg_access`

## Requirements
- R1: After reset, all four register locations read 0x00 and neither target request is high.
- R2: Command byte fields: bit 0 busy (read only), bit 1 write, bit 2 read, bit 3 PHY select (clear means EEPROM), bit 4 EEPROM write enable. When the block is idle, a command with exactly one of bits 1 and 2 set makes busy read 1 from the next clock. Only the selected target's request is raised.
- R3: A read with command 0x04 returns the EEPROM word at the 6-bit offset held in address bits 5:0. The low byte appears at location 2 and the high byte at location 3 once busy clears.
- R4: A read with command 0x0C returns the PHY register at address bits 5:0. While that request is high, the PHY field output carries address bits 7:6, and bit 6 is set for PHY accesses.
- R5: Command 0x12 writes the data word (low byte at location 2) to the EEPROM offset.
- R6: Command 0x1A writes the data word to the PHY register.
- R7: An EEPROM write with bit 4 clear (command 0x02) raises no EEPROM request and leaves memory unchanged. Busy still sets and clears.
- R8: While busy is set, host writes to the command, address and data locations have no effect.
- R9: A command with both bits 1 and 2 set starts nothing. Busy stays 0 and no request is raised.
- R10: After a transaction completes, the command location reads the issued command with bit 0 clear. Writing 0x00 makes it read 0x00.
- R11: Busy stays set until the selected target acknowledges. The data bytes keep their previous value until a read acknowledge loads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 2 | Host register location |
| reg_wdata_i | input | 8 | Host write byte |
| reg_rdata_o | output | 8 | Host read byte for reg_addr_i |
| ee_req_o | output | 1 | EEPROM request |
| ee_we_o | output | 1 | EEPROM write flag |
| ee_addr_o | output | 6 | EEPROM word offset |
| ee_wdata_o | output | 16 | EEPROM write word |
| ee_rdata_i | input | 16 | EEPROM read word |
| ee_ack_i | input | 1 | EEPROM acknowledge |
| phy_req_o | output | 1 | PHY request |
| phy_we_o | output | 1 | PHY write flag |
| phy_dev_o | output | 2 | PHY address field |
| phy_addr_o | output | 6 | PHY register number |
| phy_wdata_o | output | 16 | PHY write word |
| phy_rdata_i | input | 16 | PHY read word |
| phy_ack_i | input | 1 | PHY acknowledge |

## Verification
The assertions check on every cycle that the two requests never overlap, that busy rises after a valid idle command and holds until an acknowledge, that it falls after one, and that a two-direction command never starts. They also check that command and address state do not move under host writes while busy, and that an EEPROM write request never goes out without the enable. Data correctness needs the bench scenarios: read words landing byte-ordered in the data locations, written words reaching the memory at the right offset, and the unenabled write leaving memory untouched.

// File: rtl/sca_pkg.sv
package sca_pkg;
  localparam int REG_AW   = 2;
  localparam int REG_W    = 8;
  localparam int DATA_W   = 16;
  localparam int OFS_W    = 6;
  localparam int NBYTES   = DATA_W / REG_W;

  localparam logic [REG_AW-1:0] LOC_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] LOC_ADDR = 2'd1;
  localparam int                LOC_DAT0 = 2;

  localparam int B_BUSY = 0;
  localparam int B_WR   = 1;
  localparam int B_RD   = 2;
  localparam int B_PHY  = 3;
  localparam int B_WEN  = 4;

  typedef struct packed {
    logic wen;
    logic phy;
    logic rd;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/sca_seq.sv
module sca_seq
  import sca_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  cmd_t cmd_i,
  input  logic ack_i,
  output logic busy_o,
  output cmd_t cmd_o,
  output logic skip_o,
  output logic rd_done_o
);
  logic busy_q, skip_q, start, done;
  cmd_t cmd_q;

  assign start = ctrl_we_i && !busy_q && (cmd_i.rd ^ cmd_i.wr);
  assign done  = busy_q && (ack_i || skip_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      skip_q <= 1'b0;
      cmd_q  <= '0;
    end else if (ctrl_we_i && !busy_q) begin
      cmd_q  <= cmd_i;
      busy_q <= start;
      // unenabled EEPROM write completes locally
      skip_q <= start && cmd_i.wr && !cmd_i.phy && !cmd_i.wen;
    end else if (done) begin
      busy_q <= 1'b0;
      skip_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign cmd_o     = cmd_q;
  assign skip_o    = skip_q;
  assign rd_done_o = done && cmd_q.rd && !skip_q;
endmodule

// File: rtl/sca_regs.sv
module sca_regs
  import sca_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [REG_W-1:0]  addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic host_we;
  assign host_we = reg_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else if (host_we && reg_addr_i == LOC_ADDR) addr_o <= reg_wdata_i;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_o[b*REG_W +: REG_W] <= '0;
      else if (load_i) data_o[b*REG_W +: REG_W] <= load_data_i[b*REG_W +: REG_W];
      else if (host_we && reg_addr_i == REG_AW'(LOC_DAT0 + b))
        data_o[b*REG_W +: REG_W] <= reg_wdata_i;
    end
  end
endmodule

// File: rtl/sca_port_mux.sv
module sca_port_mux
  import sca_pkg::*;
(
  input  logic              busy_i,
  input  logic              skip_i,
  input  cmd_t              cmd_i,
  output logic              ee_req_o,
  output logic              phy_req_o,
  input  logic              ee_ack_i,
  input  logic              phy_ack_i,
  input  logic [DATA_W-1:0] ee_rdata_i,
  input  logic [DATA_W-1:0] phy_rdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  assign ee_req_o  = busy_i && !cmd_i.phy && !skip_i;
  assign phy_req_o = busy_i && cmd_i.phy;
  assign ack_o     = cmd_i.phy ? phy_ack_i : (ee_ack_i && !skip_i);
  assign rdata_o   = cmd_i.phy ? phy_rdata_i : ee_rdata_i;
endmodule

// File: rtl/shared_cfg_access.sv
module shared_cfg_access
  import sca_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              ee_req_o,
  output logic              ee_we_o,
  output logic [OFS_W-1:0]  ee_addr_o,
  output logic [DATA_W-1:0] ee_wdata_o,
  input  logic [DATA_W-1:0] ee_rdata_i,
  input  logic              ee_ack_i,
  output logic              phy_req_o,
  output logic              phy_we_o,
  output logic [1:0]        phy_dev_o,
  output logic [OFS_W-1:0]  phy_addr_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic [DATA_W-1:0] phy_rdata_i,
  input  logic              phy_ack_i
);
  logic              busy, skip, rd_done, ack;
  cmd_t              cmd_in, cmd;
  logic [REG_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q, tgt_rdata;
  logic              unused_wd;

  assign cmd_in = '{wen: reg_wdata_i[B_WEN], phy: reg_wdata_i[B_PHY],
                    rd: reg_wdata_i[B_RD], wr: reg_wdata_i[B_WR]};
  assign unused_wd = ^{reg_wdata_i[REG_W-1:B_WEN+1], reg_wdata_i[B_BUSY]};

  sca_seq u_seq (
    .clk_i, .rst_ni,
    .ctrl_we_i (reg_we_i && reg_addr_i == LOC_CTRL),
    .cmd_i     (cmd_in),
    .ack_i     (ack),
    .busy_o    (busy),
    .cmd_o     (cmd),
    .skip_o    (skip),
    .rd_done_o (rd_done)
  );

  sca_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .busy_i      (busy),
    .load_i      (rd_done),
    .load_data_i (tgt_rdata),
    .addr_o      (addr_q),
    .data_o      (data_q)
  );

  sca_port_mux u_mux (
    .busy_i      (busy),
    .skip_i      (skip),
    .cmd_i       (cmd),
    .ee_req_o, .phy_req_o, .ee_ack_i, .phy_ack_i, .ee_rdata_i, .phy_rdata_i,
    .ack_o       (ack),
    .rdata_o     (tgt_rdata)
  );

  assign ee_we_o     = cmd.wr;
  assign phy_we_o    = cmd.wr;
  assign ee_addr_o   = addr_q[OFS_W-1:0];
  assign phy_addr_o  = addr_q[OFS_W-1:0];
  assign phy_dev_o   = addr_q[REG_W-1:OFS_W];
  assign ee_wdata_o  = data_q;
  assign phy_wdata_o = data_q;

  always_comb begin
    case (reg_addr_i)
      LOC_CTRL: reg_rdata_o = {3'b000, cmd.wen, cmd.phy, cmd.rd, cmd.wr, busy};
      LOC_ADDR: reg_rdata_o = addr_q;
      2'd2:     reg_rdata_o = data_q[REG_W-1:0];
      default:  reg_rdata_o = data_q[DATA_W-1:REG_W];
    endcase
  end
endmodule

// File: rtl/sca_checker.sv
module sca_checker
  import sca_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              ee_req_o,
  input logic              ee_we_o,
  input logic              ee_ack_i,
  input logic              phy_req_o,
  input logic              phy_ack_i,
  input logic              busy,
  input cmd_t              cmd,
  input logic [REG_W-1:0]  addr_q
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && reg_addr_i == LOC_CTRL;

  assert_req_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ee_req_o && phy_req_o));

  assert_busy_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && ctrl_wr && (reg_wdata_i[B_RD] ^ reg_wdata_i[B_WR])) |=> busy);

  assert_ack_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ((ee_req_o && ee_ack_i) || (phy_req_o && phy_ack_i))) |=> !busy);

  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (ee_req_o || phy_req_o) && !ee_ack_i && !phy_ack_i) |=> busy);

  assert_phy_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> cmd.phy);

  assert_wen_guard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_req_o && ee_we_o) |-> cmd.wen);

  assert_cmd_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ctrl_wr) |=> $stable(cmd));

  assert_addr_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && reg_addr_i == LOC_ADDR) |=> $stable(addr_q));

  assert_noop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && ctrl_wr && reg_wdata_i[B_RD] && reg_wdata_i[B_WR]) |=> !busy);
endmodule

bind shared_cfg_access sca_checker u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .ee_req_o, .ee_we_o, .ee_ack_i, .phy_req_o, .phy_ack_i,
  .busy (busy), .cmd (cmd), .addr_q (addr_q)
);

// File: tb/shared_cfg_access_tb_top.sv
`timescale 1ns/1ps
module shared_cfg_access_tb_top;
  localparam int LAT = 3;
  localparam int POLL_MAX = 100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        ee_req_o, ee_we_o, phy_req_o, phy_we_o;
  logic [5:0]  ee_addr_o, phy_addr_o;
  logic [1:0]  phy_dev_o;
  logic [15:0] ee_wdata_o, phy_wdata_o;
  logic [15:0] ee_rdata_i = '0, phy_rdata_i = '0;
  logic        ee_ack_i = 1'b0, phy_ack_i = 1'b0;

  logic [15:0] ee_mem [64];
  logic [15:0] phy_mem [64];
  int ee_cnt = 0, phy_cnt = 0, ee_reqs = 0, phy_reqs = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  shared_cfg_access dut_i (.*);

  always @(negedge clk_i) begin
    if (ee_req_o) ee_reqs++;
    if (phy_req_o) phy_reqs++;
    if (ee_ack_i) ee_ack_i = 1'b0;
    else if (ee_req_o) begin
      if (ee_cnt == LAT) begin
        ee_cnt = 0; ee_ack_i = 1'b1;
        if (ee_we_o) ee_mem[ee_addr_o] = ee_wdata_o; else ee_rdata_i = ee_mem[ee_addr_o];
      end else ee_cnt++;
    end else ee_cnt = 0;
    if (phy_ack_i) phy_ack_i = 1'b0;
    else if (phy_req_o) begin
      if (phy_cnt == LAT) begin
        phy_cnt = 0; phy_ack_i = 1'b1;
        if (phy_we_o) phy_mem[phy_addr_o] = phy_wdata_o; else phy_rdata_i = phy_mem[phy_addr_o];
      end else phy_cnt++;
    end else phy_cnt = 0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle(string req);
    logic [7:0] c;
    for (int i = 0; i < POLL_MAX; i++) begin
      @(negedge clk_i);
      rd_reg(2'd0, c);
      if (!c[0]) return;
    end
    chk({req, " busy timeout"}, 1, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], v);
      chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 requests after reset", {ee_req_o, phy_req_o}, 2'b00);
  endtask

  task automatic t_ee_read(logic [5:0] ofs);
    logic [7:0] v, lo, hi;
    wr_reg(2'd2, 8'h11); wr_reg(2'd3, 8'h22);
    wr_reg(2'd1, {2'b00, ofs});
    wr_reg(2'd0, 8'h04);
    rd_reg(2'd0, v);
    chk("R2 busy after ee read cmd", v, 8'h05);
    chk("R2 ee request only", {ee_req_o, phy_req_o}, 2'b10);
    rd_reg(2'd2, v);
    chk("R11 data held before ack", v, 8'h11);
    wait_idle("R11");
    rd_reg(2'd2, lo); rd_reg(2'd3, hi);
    chk("R3 ee read word", {hi, lo}, ee_mem[ofs]);
    rd_reg(2'd0, v);
    chk("R10 cmd after done", v, 8'h04);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, v);
    chk("R10 cmd cleared", v, 8'h00);
  endtask

  task automatic t_phy_read(logic [5:0] r);
    logic [7:0] v, lo, hi;
    wr_reg(2'd1, {2'b01, r});
    wr_reg(2'd0, 8'h0C);
    rd_reg(2'd0, v);
    chk("R2 busy after phy read cmd", v, 8'h0D);
    chk("R4 phy request only", {ee_req_o, phy_req_o}, 2'b01);
    chk("R4 phy field", phy_dev_o, 2'b01);
    wait_idle("R4");
    rd_reg(2'd2, lo); rd_reg(2'd3, hi);
    chk("R4 phy read word", {hi, lo}, phy_mem[r]);
    wr_reg(2'd0, 8'h00);
  endtask

  task automatic t_ee_write(logic [5:0] ofs, logic [15:0] w);
    logic [7:0] lo, hi;
    wr_reg(2'd2, w[7:0]); wr_reg(2'd3, w[15:8]);
    wr_reg(2'd1, {2'b00, ofs});
    wr_reg(2'd0, 8'h12);
    wait_idle("R5");
    chk("R5 ee memory written", ee_mem[ofs], w);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h00); wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'h04);
    wait_idle("R5");
    rd_reg(2'd2, lo); rd_reg(2'd3, hi);
    chk("R5 ee readback", {hi, lo}, w);
    wr_reg(2'd0, 8'h00);
  endtask

  task automatic t_phy_write(logic [5:0] r, logic [15:0] w);
    wr_reg(2'd2, w[7:0]); wr_reg(2'd3, w[15:8]);
    wr_reg(2'd1, {2'b01, r});
    wr_reg(2'd0, 8'h1A);
    wait_idle("R6");
    chk("R6 phy register written", phy_mem[r], w);
    wr_reg(2'd0, 8'h00);
  endtask

  task automatic t_wen_clear(logic [5:0] ofs);
    logic [15:0] old;
    logic [7:0] v;
    int reqs;
    old = ee_mem[ofs]; reqs = ee_reqs;
    wr_reg(2'd2, 8'hEE); wr_reg(2'd3, 8'hBB);
    wr_reg(2'd1, {2'b00, ofs});
    wr_reg(2'd0, 8'h02);
    rd_reg(2'd0, v);
    chk("R7 busy set for unenabled write", v[0], 1'b1);
    wait_idle("R7");
    chk("R7 no ee request", ee_reqs - reqs, 0);
    chk("R7 memory unchanged", ee_mem[ofs], old);
    wr_reg(2'd0, 8'h00);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v;
    int preqs;
    preqs = phy_reqs;
    wr_reg(2'd2, 8'h34); wr_reg(2'd3, 8'h12);
    wr_reg(2'd1, 8'h05);
    wr_reg(2'd0, 8'h12);
    wr_reg(2'd0, 8'h0C);
    wr_reg(2'd1, 8'h3F);
    wr_reg(2'd2, 8'h99);
    wait_idle("R8");
    rd_reg(2'd0, v);
    chk("R8 cmd kept while busy", v, 8'h12);
    rd_reg(2'd1, v);
    chk("R8 address kept while busy", v, 8'h05);
    chk("R8 data kept while busy", ee_mem[5], 16'h1234);
    chk("R8 no phy request", phy_reqs - preqs, 0);
    wr_reg(2'd0, 8'h00);
  endtask

  task automatic t_both;
    logic [7:0] v;
    int er, pr;
    er = ee_reqs; pr = phy_reqs;
    wr_reg(2'd0, 8'h06);
    rd_reg(2'd0, v);
    chk("R9 no busy for both bits", v, 8'h06);
    repeat (LAT + 2) @(negedge clk_i);
    chk("R9 no requests", (ee_reqs - er) + (phy_reqs - pr), 0);
    wr_reg(2'd0, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      ee_mem[i]  = 16'hA000 ^ 16'(i * 16'h0135);
      phy_mem[i] = 16'h7800 + 16'(i);
    end
    #1 t_reset;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_ee_read(6'd0);
    t_ee_read(6'd63);
    t_ee_read(6'd21);
    t_phy_read(6'd1);
    t_phy_read(6'd31);
    t_ee_write(6'd9, 16'hBEEF);
    t_ee_write(6'd63, 16'h0001);
    t_phy_write(6'd4, 16'h01E1);
    t_phy_read(6'd4);
    t_wen_clear(6'd9);
    t_busy_ignore;
    t_both;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule